// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address for every beat of an SDRAM read or write burst. A column command supplies the starting column. The block then presents one column address per clock for as long as the burst lasts, with a valid flag and a flag on the final beat. The beat order follows a stored mode: a burst length of 1, 2, 4 or 8 beats or a full row, and either linear or interleaved ordering inside the aligned block of beats.

The mode is loaded by a mode-load strobe, and only while no burst is running. A column command arriving within two clocks of an accepted load is refused. A stop request ends the burst at any length, including a full-row burst. A new column command on any clock abandons the running burst and starts a fresh one. The column width is a parameter: 10 bits for a by-8 organisation and 9 bits for a by-16 one.

Top module: `sdr_col_sequencer`

## Requirements
- R1: After synchronous reset, `beat_valid`, `last_beat` and `col_out` are all 0. The stored mode is a 1-beat linear burst. `col_out` is 0 whenever `beat_valid` is 0.
- R2: In linear order with length N (`mode_len` 3'b001=2, 3'b010=4, 3'b011=8), beat k carries the start column with its low log2(N) bits replaced by (start + k) mod N. The upper bits stay fixed.
- R3: In interleaved order (`mode_interleave`=1) with length N, beat k carries the start column with its low log2(N) bits XORed with k.
- R4: For a fixed length (`mode_len` 3'b000=1, or 2, 4, 8), `last_beat` is 1 exactly on beat N-1. If no new command arrives, `beat_valid` is 0 on the following clock. The first beat appears the clock after the command is accepted.
- R5: With `mode_len`=3'b111 (full row), beat k carries (start + k) mod 2^COL_W, whatever the value of `mode_interleave`. `last_beat` never rises in this mode, and the burst runs until stopped or replaced.
- R6: `stop_req` without `cmd_start` drops `beat_valid` on the next clock, at any burst length.
- R7: A `cmd_start` accepted while a burst runs restarts from beat 0 at the new column on the next clock. `cmd_start` takes priority over `stop_req` on the same clock.
- R8: `cmd_start` on either of the two clocks after an accepted mode load is ignored. On the third clock it is accepted.
- R9: `mode_load` is ignored while `beat_valid` is 1. The running burst and the following bursts keep the old mode.
- R10: `mode_load` with a length code of 3'b100, 3'b101 or 3'b110 is ignored and leaves the stored mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_load | input | 1 | Strobe that loads length and order |
| mode_len | input | 3 | Length code: 000=1, 001=2, 010=4, 011=8, 111=full row |
| mode_interleave | input | 1 | 1 selects interleaved order, 0 linear |
| cmd_start | input | 1 | Column command; starts or restarts a burst |
| cmd_col | input | COL_W | Starting column for the command |
| stop_req | input | 1 | Ends the running burst |
| beat_valid | output | 1 | A burst beat is presented this clock |
| col_out | output | COL_W | Column address of the current beat |
| last_beat | output | 1 | Final beat of a fixed-length burst |

## Verification
The assertions take several things for granted. Each stored length is a legal code. A mode load only takes effect while idle. Once a burst has started, its mode stays constant until the burst ends, so the upper column bits of a fixed burst and the +1 step of a full-row burst can be checked between neighbouring clocks. The stimulus keeps to this by issuing mode loads only between bursts, except in the one scenario that shows a load during a burst being refused. Column commands are held back until the two-clock settling window has passed, except in the scenario that probes that window.

// File: rtl/sdr_colseq_pkg.sv
package sdr_colseq_pkg;

    typedef enum logic [2:0] {
        BL_ONE   = 3'b000,
        BL_TWO   = 3'b001,
        BL_FOUR  = 3'b010,
        BL_EIGHT = 3'b011,
        BL_PAGE  = 3'b111
    } blen_e;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } border_e;

    typedef struct packed {
        blen_e   len;
        border_e order;
    } mode_t;

    localparam mode_t MODE_RESET    = '{len: BL_ONE, order: ORD_LINEAR};
    localparam int    SETTLE_CYCLES = 2;
    localparam int    WRAP_BITS     = 3;   // widest fixed burst is 8 beats

    // True when a length code names a supported burst length
    function automatic logic len_code_ok(input logic [2:0] code);
        case (code)
            3'b000, 3'b001, 3'b010, 3'b011, 3'b111: len_code_ok = 1'b1;
            default:                                len_code_ok = 1'b0;
        endcase
    endfunction

    // Mask of the low column bits that wrap inside a fixed burst
    function automatic logic [WRAP_BITS-1:0] wrap_mask(input blen_e len);
        case (len)
            BL_TWO:   wrap_mask = 3'b001;
            BL_FOUR:  wrap_mask = 3'b011;
            BL_EIGHT: wrap_mask = 3'b111;
            default:  wrap_mask = 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg
    import sdr_colseq_pkg::*;
#(
    parameter int SETTLE = SETTLE_CYCLES
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load_req,
    input  logic [2:0] len_code,
    input  logic       order_bit,
    input  logic       burst_active,
    output mode_t      mode_q,
    output logic       cmd_allow
);
    localparam int CNT_W = $clog2(SETTLE + 1);

    logic [CNT_W-1:0] settle_cnt;
    logic             load_ok;

    // Load only while idle, and only with a legal length code
    assign load_ok   = load_req && !burst_active && len_code_ok(len_code);
    assign cmd_allow = (settle_cnt == '0) && !load_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= MODE_RESET;
            settle_cnt <= '0;
        end else if (load_ok) begin
            mode_q.len   <= blen_e'(len_code);
            mode_q.order <= border_e'(order_bit);
            settle_cnt   <= CNT_W'(SETTLE);
        end else if (settle_cnt != '0) begin
            settle_cnt <= settle_cnt - 1'b1;
        end
    end

endmodule

// File: rtl/sdr_beat_ctrl.sv
module sdr_beat_ctrl
    import sdr_colseq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             stop,
    input  mode_t            mode,
    output logic             valid_q,
    output logic [COL_W-1:0] start_q,
    output logic [COL_W-1:0] beat_idx,
    output logic             last
);
    localparam int PAD_W = COL_W - WRAP_BITS;

    logic [COL_W-1:0] final_idx;

    assign final_idx = {{PAD_W{1'b0}}, wrap_mask(mode.len)};
    assign last      = valid_q && (mode.len != BL_PAGE) && (beat_idx == final_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            start_q  <= '0;
            beat_idx <= '0;
        end else if (start) begin
            valid_q  <= 1'b1;
            start_q  <= start_col;
            beat_idx <= '0;
        end else if (stop) begin
            valid_q  <= 1'b0;
        end else if (valid_q) begin
            if (last) valid_q  <= 1'b0;
            else      beat_idx <= beat_idx + 1'b1;
        end
    end

endmodule

// File: rtl/sdr_col_gen.sv
module sdr_col_gen
    import sdr_colseq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] start_col,
    input  logic [COL_W-1:0] beat_idx,
    input  mode_t            mode,
    output logic [COL_W-1:0] col
);
    localparam int PAD_W = COL_W - WRAP_BITS;

    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] summed;
    logic [COL_W-1:0] toggled;

    assign mask    = {{PAD_W{1'b0}}, wrap_mask(mode.len)};
    assign summed  = start_col + beat_idx;
    assign toggled = start_col ^ beat_idx;

    always_comb begin
        if (mode.len == BL_PAGE)
            col = summed;
        else if (mode.order == ORD_XOR)
            col = (start_col & ~mask) | (toggled & mask);
        else
            col = (start_col & ~mask) | (summed & mask);
    end

endmodule

// File: rtl/sdr_col_sequencer.sv
module sdr_col_sequencer
    import sdr_colseq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_load,
    input  logic [2:0]       mode_len,
    input  logic             mode_interleave,
    input  logic             cmd_start,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             stop_req,
    output logic             beat_valid,
    output logic [COL_W-1:0] col_out,
    output logic             last_beat
);
    mode_t            mode_q;
    logic             cmd_allow;
    logic             cmd_take;
    logic [COL_W-1:0] start_q;
    logic [COL_W-1:0] beat_idx;
    logic [COL_W-1:0] gen_col;

    sdr_mode_reg #(.SETTLE(SETTLE_CYCLES)) u_mode (
        .clk          (clk),
        .rst          (rst),
        .load_req     (mode_load),
        .len_code     (mode_len),
        .order_bit    (mode_interleave),
        .burst_active (beat_valid),
        .mode_q       (mode_q),
        .cmd_allow    (cmd_allow)
    );

    assign cmd_take = cmd_start && cmd_allow;

    sdr_beat_ctrl #(.COL_W(COL_W)) u_beat (
        .clk       (clk),
        .rst       (rst),
        .start     (cmd_take),
        .start_col (cmd_col),
        .stop      (stop_req),
        .mode      (mode_q),
        .valid_q   (beat_valid),
        .start_q   (start_q),
        .beat_idx  (beat_idx),
        .last      (last_beat)
    );

    sdr_col_gen #(.COL_W(COL_W)) u_gen (
        .start_col (start_q),
        .beat_idx  (beat_idx),
        .mode      (mode_q),
        .col       (gen_col)
    );

    assign col_out = beat_valid ? gen_col : '0;

endmodule

// File: rtl/sdr_col_sequencer_chk.sv
module sdr_col_sequencer_chk
    import sdr_colseq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             mode_load,
    input logic [2:0]       mode_len,
    input logic             cmd_start,
    input logic [COL_W-1:0] cmd_col,
    input logic             stop_req,
    input logic             beat_valid,
    input logic [COL_W-1:0] col_out,
    input logic             last_beat,
    input mode_t            mode_q
);

    // R1: idle output carries no column
    a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !beat_valid |-> (col_out == '0) && !last_beat);

    // R2: upper column bits hold between beats of a fixed burst
    a_r2_upper_stable: assert property (@(posedge clk) disable iff (rst)
        beat_valid && !last_beat && !cmd_start && !stop_req && (mode_q.len != BL_PAGE)
        |=> beat_valid && $stable(col_out[COL_W-1:WRAP_BITS]));

    // R4: the final beat closes the burst
    a_r4_last_closes: assert property (@(posedge clk) disable iff (rst)
        last_beat && !cmd_start |=> !beat_valid);

    // R5: full-row bursts never flag a last beat and step by one
    a_r5_page_no_last: assert property (@(posedge clk) disable iff (rst)
        (mode_q.len == BL_PAGE) |-> !last_beat);

    a_r5_page_step: assert property (@(posedge clk) disable iff (rst)
        beat_valid && !cmd_start && !stop_req && (mode_q.len == BL_PAGE)
        |=> beat_valid && (col_out == $past(col_out) + 1'b1));

    // R6: a stop request ends the burst
    a_r6_stop_ends: assert property (@(posedge clk) disable iff (rst)
        stop_req && !cmd_start |=> !beat_valid);

    // R7: a command during a burst restarts at the new column
    a_r7_restart: assert property (@(posedge clk) disable iff (rst)
        cmd_start && beat_valid |=> beat_valid && (col_out == $past(cmd_col)));

    // R8: two clocks of silence after an accepted mode load
    a_r8_settle: assert property (@(posedge clk) disable iff (rst)
        mode_load && !beat_valid && len_code_ok(mode_len)
        |=> !beat_valid ##1 !beat_valid ##1 !beat_valid);

endmodule

bind sdr_col_sequencer sdr_col_sequencer_chk #(.COL_W(COL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_load  (mode_load),
    .mode_len   (mode_len),
    .cmd_start  (cmd_start),
    .cmd_col    (cmd_col),
    .stop_req   (stop_req),
    .beat_valid (beat_valid),
    .col_out    (col_out),
    .last_beat  (last_beat),
    .mode_q     (mode_q)
);

// File: tb/sdr_col_sequencer_test.sv
module sdr_col_sequencer_test;
    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_load = 1'b0;
    logic [2:0]    mode_len = 3'b000;
    logic          mode_interleave = 1'b0;
    logic          cmd_start = 1'b0;
    logic [CW-1:0] cmd_col = '0;
    logic          stop_req = 1'b0;
    logic          beat_valid;
    logic [CW-1:0] col_out;
    logic          last_beat;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    sdr_col_sequencer #(.COL_W(CW)) uut (
        .clk(clk), .rst(rst), .mode_load(mode_load), .mode_len(mode_len),
        .mode_interleave(mode_interleave), .cmd_start(cmd_start), .cmd_col(cmd_col),
        .stop_req(stop_req), .beat_valid(beat_valid), .col_out(col_out),
        .last_beat(last_beat)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check_beat(input string req, input logic ev, input logic el, input int ec);
        checks++;
        if (beat_valid !== ev || last_beat !== el || col_out !== CW'(ec)) begin
            errors++;
            $display("FAIL %s: actual valid=%0b last=%0b col=%0d expected valid=%0b last=%0b col=%0d",
                     req, beat_valid, last_beat, col_out, ev, el, ec);
        end
    endtask

    // Column for beat k, computed straight from the requirements
    function automatic int exp_col(int start, int k, int lg, bit page, bit ilv);
        int n, base, off;
        if (page) return (start + k) % (1 << CW);
        n    = 1 << lg;
        off  = start % n;
        base = start - off;
        if (ilv) return base + (off ^ k);
        return base + ((off + k) % n);
    endfunction

    task automatic program_mode(input logic [2:0] code, input logic ilv);
        mode_load = 1'b1; mode_len = code; mode_interleave = ilv;
        tick();
        mode_load = 1'b0;
        tick();
        tick();
    endtask

    task automatic run_fixed(input string req, input int start, input int lg, input bit ilv);
        int n = 1 << lg;
        cmd_start = 1'b1; cmd_col = CW'(start);
        tick();
        cmd_start = 1'b0;
        for (int k = 0; k < n; k++) begin
            if (k > 0) tick();
            check_beat(req, 1'b1, (k == n - 1), exp_col(start, k, lg, 1'b0, ilv));
        end
        tick();
        check_beat(req, 1'b0, 1'b0, 0);
    endtask

    task automatic t_reset();
        tick();
        check_beat("R1", 1'b0, 1'b0, 0);
    endtask

    task automatic t_linear();
        program_mode(3'b010, 1'b0);
        run_fixed("R2", 5, 2, 1'b0);
        run_fixed("R2", 1022, 2, 1'b0);
        program_mode(3'b011, 1'b0);
        run_fixed("R2", 'h3E, 3, 1'b0);
    endtask

    task automatic t_interleave();
        program_mode(3'b011, 1'b1);
        run_fixed("R3", 'h3D, 3, 1'b1);
        program_mode(3'b010, 1'b1);
        run_fixed("R3", 6, 2, 1'b1);
    endtask

    task automatic t_short();
        program_mode(3'b000, 1'b0);
        run_fixed("R4", 77, 0, 1'b0);
        program_mode(3'b001, 1'b1);
        run_fixed("R4", 9, 1, 1'b1);
    endtask

    task automatic t_page();
        program_mode(3'b111, 1'b1);   // R5: interleave bit has no effect
        cmd_start = 1'b1; cmd_col = CW'(1021);
        tick();
        cmd_start = 1'b0;
        for (int k = 0; k < 8; k++) begin
            if (k > 0) tick();
            check_beat("R5", 1'b1, 1'b0, exp_col(1021, k, 0, 1'b1, 1'b0));
        end
        stop_req = 1'b1;
        tick();
        stop_req = 1'b0;
        check_beat("R6", 1'b0, 1'b0, 0);
    endtask

    task automatic t_stop();
        program_mode(3'b011, 1'b1);
        cmd_start = 1'b1; cmd_col = CW'('h40);
        tick();
        cmd_start = 1'b0;
        check_beat("R6", 1'b1, 1'b0, 'h40);
        tick();
        check_beat("R6", 1'b1, 1'b0, 'h41);
        stop_req = 1'b1;
        tick();
        stop_req = 1'b0;
        check_beat("R6", 1'b0, 1'b0, 0);
        // R7: command and stop together, the command wins
        cmd_start = 1'b1; stop_req = 1'b1; cmd_col = CW'('h44);
        tick();
        cmd_start = 1'b0; stop_req = 1'b0;
        check_beat("R7", 1'b1, 1'b0, 'h44);
        stop_req = 1'b1;
        tick();
        stop_req = 1'b0;
        check_beat("R6", 1'b0, 1'b0, 0);
    endtask

    task automatic t_interrupt();
        program_mode(3'b011, 1'b0);
        cmd_start = 1'b1; cmd_col = CW'('h10);
        tick();
        cmd_start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            if (k > 0) tick();
            check_beat("R7", 1'b1, 1'b0, 'h10 + k);
        end
        run_fixed("R7", 'h25, 3, 1'b0);
    endtask

    task automatic t_settle();
        mode_load = 1'b1; mode_len = 3'b010; mode_interleave = 1'b0;
        tick();
        mode_load = 1'b0;
        cmd_start = 1'b1; cmd_col = CW'('h30);
        tick();
        check_beat("R8", 1'b0, 1'b0, 0);
        tick();
        check_beat("R8", 1'b0, 1'b0, 0);
        tick();
        cmd_start = 1'b0;
        check_beat("R8", 1'b1, 1'b0, 'h30);
        for (int k = 1; k < 4; k++) begin
            tick();
            check_beat("R8", 1'b1, (k == 3), 'h30 + k);
        end
        tick();
        check_beat("R8", 1'b0, 1'b0, 0);
    endtask

    task automatic t_busy_load();
        program_mode(3'b010, 1'b0);
        cmd_start = 1'b1; cmd_col = CW'('h50);
        tick();
        cmd_start = 1'b0;
        check_beat("R9", 1'b1, 1'b0, 'h50);
        mode_load = 1'b1; mode_len = 3'b011; mode_interleave = 1'b1;
        tick();
        mode_load = 1'b0;
        check_beat("R9", 1'b1, 1'b0, 'h51);
        tick();
        check_beat("R9", 1'b1, 1'b0, 'h52);
        tick();
        check_beat("R9", 1'b1, 1'b1, 'h53);
        tick();
        check_beat("R9", 1'b0, 1'b0, 0);
        run_fixed("R9", 'h61, 2, 1'b0);
    endtask

    task automatic t_reserved();
        program_mode(3'b001, 1'b0);
        program_mode(3'b101, 1'b1);
        run_fixed("R10", 'h71, 1, 1'b0);
        program_mode(3'b110, 1'b0);
        run_fixed("R10", 'h72, 1, 1'b0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R1: actual=watchdog timeout expected=run completion");
        finish_run();
    end

    initial begin
        tick();
        tick();
        rst = 1'b0;
        t_reset();
        t_linear();
        t_interleave();
        t_short();
        t_page();
        t_stop();
        t_interrupt();
        t_settle();
        t_busy_load();
        t_reserved();
        finish_run();
    end

endmodule